// File: doc/BRIEF.md
# Locked Extended Register File

This block is an indexed register file reached through an index/data port pair, in the manner of a display controller's CRT register bank. The host loads an 8-bit index through the index port. It then reads the addressed register combinationally, or writes it through the data port on a clock edge. The index stays put between data accesses, so the host can write or read the same register again and again without reloading it.

Most registers sit behind two key registers. The first key opens the first tier of extended registers. The second key opens a further register, and that register also needs the first key to be open. A locked register ignores writes and reads back as zero. The key registers themselves can always be read and written. A fixed identification byte can be read once the first tier is open.

Fields that are split across several indices are joined and driven as outputs: a 6-bit bank number, the three high bits of the display start address, and a 10-bit linear aperture base in units of 4 MB. A separate flag selects the alternate I/O base addresses for an accelerator.

Top module: `xreg_file`

## Requirements
- R1: A pulse on `idx_we` loads `wdata` into the 8-bit index register. The index keeps its value across any number of data-port accesses.
- R2: Key A sits at index 38h. It is always readable and writable and reads back the value last written to it. Tier A is open only while key A holds 48h. Writing 00h, or any other value, closes tier A.
- R3: Key B sits at index 39h. It is always readable and writable and reads back the value last written to it. Tier B is open only while key B holds A5h. Writing 5Ah, or any other value, closes tier B.
- R4: After reset, the index, both keys and all stored registers are 00h, both tiers are locked, and every composed output is zero.
- R5: The tier-A registers are at indices 30h, 31h, 35h, 43h, 59h and 5Ah. While tier A is closed they read 00h and ignore writes.
- R6: Index 51h can be read and written only while both tiers are open. At any other time it reads 00h and ignores writes.
- R7: Index 30h returns the parameter `CHIP_ID` (default 91h) while tier A is open. Writes to index 30h have no effect.
- R8: `bank_num[3:0]` equals bits 3..0 of index 35h, and `bank_num[5:4]` equals bits 3..2 of index 51h.
- R9: `disp_start_hi[1:0]` equals bits 5..4 of index 31h, and `disp_start_hi[2]` equals bit 0 of index 51h.
- R10: `aperture_base[7:0]` equals index 5Ah, and `aperture_base[9:8]` equals bits 1..0 of index 59h.
- R11: `alt_io_sel` equals bit 4 of index 43h.
- R12: Any index not listed above reads 00h, and writes to it change no register.
- R13: A data write to an open register stores all 8 bits, and they are visible on `rdata` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Load the index register from `wdata` |
| data_we | input | 1 | Write `wdata` to the register at the current index |
| wdata | input | 8 | Write data for both ports |
| rdata | output | 8 | Contents of the register at the current index (combinational) |
| bank_num | output | 6 | Composed 64 KB bank number |
| disp_start_hi | output | 3 | Display start address bits 18..16 |
| aperture_base | output | 10 | Linear aperture base in units of 4 MB |
| alt_io_sel | output | 1 | Alternate accelerator I/O base select |

## Verification
The hardest case to reach is index 51h while exactly one of the two tiers is open. Reaching it needs a sequence of key writes, then a data write that must leave the high bank and display-start bits unchanged, then a reopen that shows the old value is still there. The bench reaches this case in several steps. It fills every index while both tiers are open, closes one key at a time and tries to overwrite 51h and 35h, and then sweeps all 256 values into each key. After each key value it reads a register it guards, so that only the single unlocking value opens that register.

// File: rtl/xreg_file.sv
module xreg_file #(
  parameter logic [7:0] CHIP_ID    = 8'h91,
  parameter logic [7:0] KEY_A_OPEN = 8'h48,
  parameter logic [7:0] KEY_B_OPEN = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_we,
  input  logic       data_we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [5:0] bank_num,
  output logic [2:0] disp_start_hi,
  output logic [9:0] aperture_base,
  output logic       alt_io_sel
);
  localparam logic [7:0] IX_ID    = 8'h30;
  localparam logic [7:0] IX_START = 8'h31;
  localparam logic [7:0] IX_BANK  = 8'h35;
  localparam logic [7:0] IX_KEYA  = 8'h38;
  localparam logic [7:0] IX_KEYB  = 8'h39;
  localparam logic [7:0] IX_MISC  = 8'h43;
  localparam logic [7:0] IX_EXT   = 8'h51;
  localparam logic [7:0] IX_APHI  = 8'h59;
  localparam logic [7:0] IX_APLO  = 8'h5A;

  logic [7:0] idx_q, key_a, key_b;
  logic [7:0] r_start, r_bank, r_misc, r_ext, r_aphi, r_aplo;
  logic       tier_a_open, tier_b_open, ext_open, wr_a;

  assign tier_a_open = (key_a == KEY_A_OPEN);
  assign tier_b_open = (key_b == KEY_B_OPEN);
  assign ext_open    = tier_a_open && tier_b_open;
  assign wr_a        = data_we && tier_a_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      key_a   <= '0;
      key_b   <= '0;
      r_start <= '0;
      r_bank  <= '0;
      r_misc  <= '0;
      r_ext   <= '0;
      r_aphi  <= '0;
      r_aplo  <= '0;
    end else begin
      if (idx_we) idx_q <= wdata;
      if (data_we && idx_q == IX_KEYA) key_a <= wdata;
      if (data_we && idx_q == IX_KEYB) key_b <= wdata;
      if (wr_a && idx_q == IX_START) r_start <= wdata;
      if (wr_a && idx_q == IX_BANK)  r_bank  <= wdata;
      if (wr_a && idx_q == IX_MISC)  r_misc  <= wdata;
      if (wr_a && idx_q == IX_APHI)  r_aphi  <= wdata;
      if (wr_a && idx_q == IX_APLO)  r_aplo  <= wdata;
      if (data_we && ext_open && idx_q == IX_EXT) r_ext <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    case (idx_q)
      IX_KEYA:  rdata = key_a;
      IX_KEYB:  rdata = key_b;
      IX_ID:    if (tier_a_open) rdata = CHIP_ID;
      IX_START: if (tier_a_open) rdata = r_start;
      IX_BANK:  if (tier_a_open) rdata = r_bank;
      IX_MISC:  if (tier_a_open) rdata = r_misc;
      IX_APHI:  if (tier_a_open) rdata = r_aphi;
      IX_APLO:  if (tier_a_open) rdata = r_aplo;
      IX_EXT:   if (ext_open)    rdata = r_ext;
      default:  rdata = '0;
    endcase
  end

  assign bank_num      = {r_ext[3:2], r_bank[3:0]};
  assign disp_start_hi = {r_ext[0], r_start[5:4]};
  assign aperture_base = {r_aphi[1:0], r_aplo};
  assign alt_io_sel    = r_misc[4];
endmodule

module xreg_file_chk #(
  parameter logic [7:0] CHIP_ID = 8'h91
) (
  input logic       clk,
  input logic       rst_n,
  input logic       idx_we,
  input logic       data_we,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] idx_q,
  input logic       tier_a_open,
  input logic       tier_b_open,
  input logic [5:0] bank_num,
  input logic [2:0] disp_start_hi
);
  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q));
  // R2
  key_a_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !idx_we && idx_q == 8'h38) |=> (rdata == $past(wdata)));
  // R5
  locked_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !tier_a_open && idx_q == 8'h35) |=> $stable(bank_num[3:0]));
  // R5
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tier_a_open && idx_q == 8'h31) |-> (rdata == 8'h00));
  // R6
  ext_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !(tier_a_open && tier_b_open) && idx_q == 8'h51)
      |=> ($stable(bank_num[5:4]) && $stable(disp_start_hi[2])));
  // R7
  chip_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tier_a_open && idx_q == 8'h30) |-> (rdata == CHIP_ID));
endmodule

bind xreg_file xreg_file_chk #(.CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
  .wdata(wdata), .rdata(rdata), .idx_q(idx_q),
  .tier_a_open(tier_a_open), .tier_b_open(tier_b_open),
  .bank_num(bank_num), .disp_start_hi(disp_start_hi)
);

// File: tb/xreg_file_bench.sv
`timescale 1ns/1ps
module xreg_file_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       idx_we = 1'b0, data_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] bank_num;
  logic [2:0] disp_start_hi;
  logic [9:0] aperture_base;
  logic       alt_io_sel;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  xreg_file u_xreg_file (
    .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
    .wdata(wdata), .rdata(rdata), .bank_num(bank_num),
    .disp_start_hi(disp_start_hi), .aperture_base(aperture_base),
    .alt_io_sel(alt_io_sel)
  );

  function automatic logic [7:0] pat(input logic [7:0] i);
    return i * 8'd37 + 8'd11;
  endfunction

  function automatic bit is_tier_a(input logic [7:0] i);
    return i == 8'h31 || i == 8'h35 || i == 8'h43 || i == 8'h59 || i == 8'h5A;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] v);
    @(negedge clk); idx_we = 1'b1; wdata = v;
    @(negedge clk); idx_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic poke(input logic [7:0] i, input logic [7:0] v);
    set_idx(i); put(v);
  endtask

  task automatic chk_outs(input string tag, input logic [7:0] v31, input logic [7:0] v35,
                          input logic [7:0] v43, input logic [7:0] v51,
                          input logic [7:0] v59, input logic [7:0] v5a);
    chk({tag, " R8 bank"}, bank_num, {v51[3:2], v35[3:0]});
    chk({tag, " R9 start"}, disp_start_hi, {v51[0], v31[5:4]});
    chk({tag, " R10 aperture"}, aperture_base, {v59[1:0], v5a});
    chk({tag, " R11 alt_io"}, alt_io_sel, v43[4]);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    chk("R4 rdata idx0", rdata, 8'h00);
    chk_outs("R4", 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);
    set_idx(8'h30); chk("R4 id locked", rdata, 8'h00);
    set_idx(8'h38); chk("R4 key A", rdata, 8'h00);
    set_idx(8'h39); chk("R4 key B", rdata, 8'h00);

    // R5 writes while fully locked are ignored
    poke(8'h35, 8'h0F); poke(8'h5A, 8'hFF);
    chk_outs("R5 locked", 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0);

    // open both tiers, then fill every index except the keys
    poke(8'h38, 8'h48); poke(8'h39, 8'hA5);
    for (int i = 0; i < 256; i++)
      if (i != 8'h38 && i != 8'h39) poke(i[7:0], pat(i[7:0]));
    for (int i = 0; i < 256; i++) begin
      logic [7:0] e;
      set_idx(i[7:0]);
      if (i == 8'h30) e = 8'h91;
      else if (i == 8'h38) e = 8'h48;
      else if (i == 8'h39) e = 8'hA5;
      else if (is_tier_a(i[7:0]) || i == 8'h51) e = pat(i[7:0]);
      else e = 8'h00;
      chk($sformatf("R13/R12/R7 open read idx %0h", i), rdata, e);
    end
    chk_outs("R8-R11 filled", pat(8'h31), pat(8'h35), pat(8'h43), pat(8'h51), pat(8'h59), pat(8'h5A));

    // R1 index kept across repeated data writes
    set_idx(8'h31); put(8'h12); put(8'h34);
    chk("R1 repeat write", rdata, 8'h34);
    chk("R1 repeat read", rdata, 8'h34);
    chk("R9 after rewrite", disp_start_hi, {pat(8'h51)[0], 2'b11});
    put(pat(8'h31));

    // R6 tier B closed
    poke(8'h39, 8'h5A);
    set_idx(8'h39); chk("R3 key B readback", rdata, 8'h5A);
    set_idx(8'h51); chk("R6 read tier B closed", rdata, 8'h00);
    put(~pat(8'h51));
    chk_outs("R6 ignored write", pat(8'h31), pat(8'h35), pat(8'h43), pat(8'h51), pat(8'h59), pat(8'h5A));
    set_idx(8'h35); chk("R5 tier A still open", rdata, pat(8'h35));

    // R6 tier A closed, tier B open
    poke(8'h39, 8'hA5); poke(8'h38, 8'h00);
    set_idx(8'h51); chk("R6 read tier A closed", rdata, 8'h00);
    put(~pat(8'h51));
    poke(8'h35, ~pat(8'h35));
    chk_outs("R5/R6 ignored", pat(8'h31), pat(8'h35), pat(8'h43), pat(8'h51), pat(8'h59), pat(8'h5A));
    for (int i = 0; i < 256; i++) begin
      set_idx(i[7:0]);
      chk($sformatf("R5 locked read idx %0h", i), rdata,
          i == 8'h39 ? 8'hA5 : 8'h00);
    end
    poke(8'h38, 8'h48);
    set_idx(8'h51); chk("R6 value kept", rdata, pat(8'h51));

    // R2 key A sweep
    for (int v = 0; v < 256; v++) begin
      poke(8'h38, v[7:0]);
      chk($sformatf("R2 key A readback %0h", v), rdata, v[7:0]);
      set_idx(8'h35);
      chk($sformatf("R2 key A %0h opens", v), rdata, v == 8'h48 ? pat(8'h35) : 8'h00);
    end
    // R3 key B sweep
    poke(8'h38, 8'h48);
    for (int v = 0; v < 256; v++) begin
      poke(8'h39, v[7:0]);
      set_idx(8'h51);
      chk($sformatf("R3 key B %0h opens", v), rdata, v == 8'hA5 ? pat(8'h51) : 8'h00);
    end

    // R10/R11 distinct patterns
    poke(8'h39, 8'hA5);
    poke(8'h59, 8'hFE); poke(8'h5A, 8'h00); poke(8'h43, 8'hEF);
    chk("R10 aperture edge", aperture_base, 10'h200);
    chk("R11 alt_io cleared", alt_io_sel, 1'b0);
    poke(8'h51, 8'h0D); poke(8'h35, 8'hF0); poke(8'h31, 8'hDF);
    chk("R8 bank edge", bank_num, 6'h30);
    chk("R9 start edge", disp_start_hi, 3'b101);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule